// File: doc/BRIEF.md
# Auto-Reload Timer with Compare, Capture and PWM

A 32-bit up-counter driven by a functional clock. A 15-bit control word configures it. The counter runs while its start bit is held. It can step on every clock or once per prescaled period. On wrap-around it either reloads a programmed value or halts as a one-shot. Software can set the counter directly with a write port. A trigger strobe copies the load value into the counter.

The same counter feeds three event sources:
- a compare against a match value;
- a wrap detector;
- a capture unit, which latches the counter when a synchronised external pin shows a selected edge.

The events set sticky flags in a 3-bit status word. Each flag is cleared by writing a one to its position. The match and wrap events can also drive a PWM pin, as one-cycle pulses or as toggles. When the timer is idle, the pin rests at a programmable default level.

Top module: `gp_timer_core`

## Requirements
- R1: After reset the counter, capture register, status flags and PWM pin are all zero.
- R2: Control bit 0 (start) is registered once. The counter advances on the second clock edge after start rises. After start clears, the counter advances at most once more and then holds.
- R3: With prescaler enable (bit 5) clear, the counter advances once per clock. With it set, the counter advances once every 2^(V+1) clocks, where V is bits 4:2. The prescale phase restarts whenever the counter is idle.
- R4: With auto-reload (bit 1) set, an advance from all ones loads load_i and sets status bit 1 (overflow).
- R5: With auto-reload clear, an advance from all ones gives zero and sets status bit 1. The counter then stays idle until start has been seen low and set again.
- R6: cnt_wr_i loads cnt_wdata_i on the next edge, ahead of any other update. Counting continues from the written value.
- R7: trig_wr_i loads load_i into the counter on the next edge, whether or not the timer runs.
- R8: Status bit 0 (match) is set when compare enable (bit 6) is set and the counter takes a value equal to match_i. It is never set with bit 6 clear.
- R9: Capture edge select is bits 9:8: 00 off, 01 rising, 10 falling, 11 both. The pin passes through a two-stage synchroniser. On a selected edge, the counter value is latched into cap_o three edges after the pin changes, and status bit 2 is set.
- R10: With capture hold (bit 13) set, cap_o is not updated while status bit 2 is set.
- R11: Writing 1 to a bit of stat_clr_i clears that status bit. A new event in the same cycle wins over the clear.
- R12: PWM trigger select is bits 11:10: 00 none, 01 overflow, 10 overflow or match. Bit 12 picks toggle (1) or one-cycle pulse away from the default (0). Both take effect on the edge of the event.
- R13: While idle, pwm_o returns to the default level in bit 7. pwm_oe_o is the inverse of bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 15 | Control word |
| load_i | input | 32 | Reload / trigger value |
| match_i | input | 32 | Compare value |
| trig_wr_i | input | 1 | Trigger strobe, reloads counter |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 32 | Counter write data |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| stat_clr_i | input | 3 | Write-one-to-clear status mask |
| cnt_o | output | 32 | Counter value |
| cap_o | output | 32 | Captured counter value |
| pwm_o | output | 1 | PWM pin |
| pwm_oe_o | output | 1 | PWM pin output enable |
| stat_o | output | 3 | Sticky event flags: match, overflow, capture |

## Verification
The counting function is tried under six prescale settings: unscaled, the shortest and a middle divider, the largest divider, and a run shorter than one divider period. Comparing the final counts distinguishes a wrong period from a wrong phase restart and from a lost or extra stop-latency step.

Wrap is driven from just below all ones with and without reload, which separates reload, one-shot halt and re-arm. Capture is tried with every edge code and both pin directions, which shows whether edge qualification is decoded correctly.

PWM runs under each trigger and shape setting. The match-plus-overflow case tells the two event sources apart by their edge timing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 32;
  localparam int PV_W   = 3;
  localparam int DIV_W  = 2 ** PV_W;
  localparam int CTRL_W = 15;
  localparam int ST_W   = 3;
  localparam int ST_MATCH = 0;
  localparam int ST_OVF   = 1;
  localparam int ST_CAP   = 2;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } cap_edge_e;

  typedef enum logic [1:0] {
    PTRG_NONE      = 2'b00,
    PTRG_OVF       = 2'b01,
    PTRG_OVF_MATCH = 2'b10,
    PTRG_RSVD      = 2'b11
  } pwm_trg_e;

  typedef struct packed {
    logic             gpo_cfg;   // 14
    logic             cap_hold;  // 13
    logic             pwm_tgl;   // 12
    pwm_trg_e         pwm_trg;   // 11:10
    cap_edge_e        cap_edge;  // 9:8
    logic             pwm_def;   // 7
    logic             cmp_en;    // 6
    logic             pre_en;    // 5
    logic [PV_W-1:0]  pre_val;   // 4:2
    logic             auto_rl;   // 1
    logic             start;     // 0
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PV_W  = 3,
  parameter int DIV_W = 2 ** PV_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            pre_en_i,
  input  logic [PV_W-1:0] pre_val_i,
  output logic            tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask   = (DIV_W'(2) << pre_val_i) - DIV_W'(1);
  assign tick_o = run_i & (~pre_en_i | ((div_q & mask) == mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else             div_q <= div_q + DIV_W'(1);
  end

  // R3: with prescale off, every running cycle ticks
  a_r3_unscaled_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !pre_en_i) |-> tick_o);
  // R3: phase restarts from zero after idle
  a_r3_phase_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i) |=> (div_q == '0));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         auto_rl_i,
  input  logic         cmp_en_i,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         trig_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] match_i,
  output logic [W-1:0] cnt_o,
  output logic         active_o,
  output logic         ovf_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, done_q;
  logic         adv, wrap, upd;

  assign active_o = run_q & ~done_q;
  assign adv      = active_o & tick_i;
  assign wrap     = adv & (&cnt_q);
  assign upd      = wr_i | trig_i | adv;
  assign ovf_o    = wrap & ~wr_i & ~trig_i;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)        cnt_d = wdata_i;
    else if (trig_i) cnt_d = load_i;
    else if (adv)    cnt_d = wrap ? (auto_rl_i ? load_i : '0) : cnt_q + W'(1);
  end

  assign match_o = cmp_en_i & upd & (cnt_d == match_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= start_i;
      if (!start_i)                done_q <= 1'b0;
      else if (ovf_o & ~auto_rl_i) done_q <= 1'b1;
    end
  end

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !wr_i && !trig_i) |=> $stable(cnt_o));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && tick_i && !wr_i && !trig_i && !(&cnt_o)) |=> (cnt_o == $past(cnt_o) + W'(1)));
  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && auto_rl_i) |=> (cnt_o == $past(load_i)));
  a_r5_oneshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !auto_rl_i) |=> (cnt_o == '0 && !active_o));
  a_r6_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_o == $past(wdata_i)));
  a_r7_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !wr_i) |=> (cnt_o == $past(load_i)));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pin_i,
  input  cap_edge_e    edge_sel_i,
  input  logic         hold_i,
  input  logic         flag_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cap_o,
  output logic         ev_o
);
  logic s1_q, s2_q, s3_q;
  logic rise, fall;

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_RISE: ev_o = rise;
      EDGE_FALL: ev_o = fall;
      EDGE_BOTH: ev_o = rise | fall;
      default:   ev_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      cap_o <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (ev_o & ~(hold_i & flag_i)) cap_o <= cnt_i;
    end
  end

  a_r9_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o && !(hold_i && flag_i)) |=> (cap_o == $past(cnt_i)));
  a_r9_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == EDGE_OFF) |=> $stable(cap_o));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && flag_i) |=> $stable(cap_o));
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
  import tmr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     active_i,
  input  logic     def_i,
  input  logic     tgl_i,
  input  pwm_trg_e trg_i,
  input  logic     ovf_i,
  input  logic     match_i,
  output logic     pwm_o
);
  logic ev;

  always_comb begin
    unique case (trg_i)
      PTRG_OVF:       ev = ovf_i;
      PTRG_OVF_MATCH: ev = ovf_i | match_i;
      default:        ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pwm_o <= 1'b0;
    else if (!active_i) pwm_o <= def_i;
    else if (tgl_i)     pwm_o <= pwm_o ^ ev;
    else                pwm_o <= ev ? ~def_i : def_i;
  end

  a_r13_idle_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i) |=> (pwm_o == $past(def_i)));
  a_r12_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && tgl_i && ev) |=> (pwm_o != $past(pwm_o)));
  a_r12_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !tgl_i && !ev) |=> (pwm_o == $past(def_i)));
endmodule

// File: rtl/gp_timer_core.sv
module gp_timer_core
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [CNT_W-1:0]  load_i,
  input  logic [CNT_W-1:0]  match_i,
  input  logic              trig_wr_i,
  input  logic              cnt_wr_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              cap_pin_i,
  input  logic [ST_W-1:0]   stat_clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic              pwm_o,
  output logic              pwm_oe_o,
  output logic [ST_W-1:0]   stat_o
);
  ctrl_t ctrl;
  logic  tick, active, ovf_ev, match_ev, cap_ev;
  logic [ST_W-1:0] st_set;
  logic [ST_W-1:0] stat_q;

  assign ctrl     = ctrl_t'(ctrl_i);
  assign pwm_oe_o = ~ctrl.gpo_cfg;

  tmr_prescale #(.PV_W(PV_W), .DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni,
    .run_i     (active),
    .pre_en_i  (ctrl.pre_en),
    .pre_val_i (ctrl.pre_val),
    .tick_o    (tick)
  );

  tmr_count #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .start_i   (ctrl.start),
    .auto_rl_i (ctrl.auto_rl),
    .cmp_en_i  (ctrl.cmp_en),
    .tick_i    (tick),
    .wr_i      (cnt_wr_i),
    .wdata_i   (cnt_wdata_i),
    .trig_i    (trig_wr_i),
    .load_i    (load_i),
    .match_i   (match_i),
    .cnt_o     (cnt_o),
    .active_o  (active),
    .ovf_o     (ovf_ev),
    .match_o   (match_ev)
  );

  tmr_capture #(.W(CNT_W)) u_cap (
    .clk_i, .rst_ni,
    .pin_i      (cap_pin_i),
    .edge_sel_i (ctrl.cap_edge),
    .hold_i     (ctrl.cap_hold),
    .flag_i     (stat_q[ST_CAP]),
    .cnt_i      (cnt_o),
    .cap_o      (cap_o),
    .ev_o       (cap_ev)
  );

  tmr_pwm u_pwm (
    .clk_i, .rst_ni,
    .active_i (active),
    .def_i    (ctrl.pwm_def),
    .tgl_i    (ctrl.pwm_tgl),
    .trg_i    (ctrl.pwm_trg),
    .ovf_i    (ovf_ev),
    .match_i  (match_ev),
    .pwm_o    (pwm_o)
  );

  always_comb begin
    st_set           = '0;
    st_set[ST_MATCH] = match_ev;
    st_set[ST_OVF]   = ovf_ev;
    st_set[ST_CAP]   = cap_ev;
  end

  for (genvar i = 0; i < ST_W; i++) begin : g_stat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[i] <= 1'b0;
      else         stat_q[i] <= st_set[i] | (stat_q[i] & ~stat_clr_i[i]);
    end

    a_r11_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_clr_i[i] && !st_set[i]) |=> !stat_o[i]);
    a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_set[i] |=> stat_o[i]);
  end

  assign stat_o = stat_q;

  // R8: no match flag source while compare disabled
  a_r8_cmp_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.cmp_en) |-> !match_ev);
endmodule

// File: tb/gp_timer_core_tb_top.sv
`timescale 1ns/1ps
module gp_timer_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] ctrl = '0;
  logic [31:0] load = '0, match = '0, wdata = '0;
  logic        trig = 1'b0, cnt_wr = 1'b0, pin = 1'b0;
  logic [2:0]  sclr = '0;
  logic [31:0] cnt, cap;
  logic        pwm, pwm_oe;
  logic [2:0]  stat;
  int checks = 0, fails = 0;
  bit finished = 0;

  localparam logic [14:0] C_ST = 15'h0001, C_AR = 15'h0002, C_PRE = 15'h0020,
    C_CE = 15'h0040, C_DEF = 15'h0080, C_HOLD = 15'h2000, C_TGL = 15'h1000,
    C_GPO = 15'h4000;
  localparam logic [14:0] E_RISE = 15'h0100, E_FALL = 15'h0200, E_BOTH = 15'h0300;
  localparam logic [14:0] T_OVF = 15'h0400, T_OVM = 15'h0800;

  // {ptv[2:0], pre_en, run_cycles[15:0], expected[15:0]}
  localparam logic [35:0] VEC [0:5] = '{
    {3'd0, 1'b0, 16'd10,  16'd10},
    {3'd0, 1'b1, 16'd10,  16'd5},
    {3'd1, 1'b1, 16'd10,  16'd2},
    {3'd2, 1'b1, 16'd20,  16'd2},
    {3'd7, 1'b1, 16'd600, 16'd2},
    {3'd2, 1'b1, 16'd7,   16'd0}
  };

  always #2 clk = ~clk;

  gp_timer_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_i(ctrl), .load_i(load), .match_i(match),
    .trig_wr_i(trig), .cnt_wr_i(cnt_wr), .cnt_wdata_i(wdata), .cap_pin_i(pin),
    .stat_clr_i(sclr), .cnt_o(cnt), .cap_o(cap), .pwm_o(pwm), .pwm_oe_o(pwm_oe),
    .stat_o(stat)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cnt(input logic [31:0] v);
    cnt_wr = 1'b1; wdata = v; step(1); cnt_wr = 1'b0;
  endtask

  task automatic clr(input logic [2:0] m);
    sclr = m; step(1); sclr = '0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v1;
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R1 reset state
    chk(cnt == 0, "R1 cnt", cnt, 0);
    chk(cap == 0, "R1 cap", cap, 0);
    chk(stat == 0, "R1 stat", {29'd0, stat}, 0);
    chk(pwm == 0, "R1 pwm", {31'd0, pwm}, 0);

    // R3/R2 prescale table
    for (int i = 0; i < 6; i++) begin
      ctrl = '0; step(2);
      wr_cnt(0);
      ctrl = C_ST | (VEC[i][32] ? C_PRE : 15'h0) | (15'(VEC[i][35:33]) << 2);
      step(int'(VEC[i][31:16]));
      ctrl = ctrl & ~C_ST;
      step(1);
      v1 = cnt;
      step(4);
      chk(cnt == 32'(VEC[i][15:0]), "R3 prescale count", cnt, 32'(VEC[i][15:0]));
      chk(cnt == v1, "R2 stop latency", cnt, v1);
    end

    // R6 write then count from it
    ctrl = '0; step(2);
    wr_cnt(32'h1234);
    chk(cnt == 32'h1234, "R6 write", cnt, 32'h1234);
    ctrl = C_ST; step(3);
    chk(cnt == 32'h1236, "R6 count from written", cnt, 32'h1236);

    // R4 auto-reload
    ctrl = '0; step(2); clr(3'b111);
    load = 32'h100;
    wr_cnt(32'hFFFF_FFFE);
    ctrl = C_ST | C_AR; step(2);
    chk(cnt == 32'hFFFF_FFFF, "R4 pre-wrap", cnt, 32'hFFFF_FFFF);
    step(1);
    chk(cnt == 32'h100, "R4 reload", cnt, 32'h100);
    chk(stat == 3'b010, "R4 ovf flag", {29'd0, stat}, 32'h2);
    ctrl = '0; step(3);
    // R11 write-one-to-clear
    clr(3'b010);
    chk(stat == 3'b000, "R11 clear", {29'd0, stat}, 0);

    // R5 one-shot
    wr_cnt(32'hFFFF_FFFE);
    ctrl = C_ST; step(3);
    chk(cnt == 0, "R5 wrap to zero", cnt, 0);
    step(4);
    chk(cnt == 0, "R5 halted", cnt, 0);
    chk(stat[1], "R5 ovf flag", {29'd0, stat}, 32'h2);
    ctrl = '0; step(2); clr(3'b010);
    ctrl = C_ST; step(3);
    chk(cnt == 2, "R5 rearm", cnt, 2);
    ctrl = '0; step(2);

    // R7 trigger
    load = 32'h55;
    trig = 1'b1; step(1); trig = 1'b0;
    chk(cnt == 32'h55, "R7 trigger reload", cnt, 32'h55);

    // R8 match
    clr(3'b111);
    match = 32'd10;
    wr_cnt(32'd8);
    ctrl = C_ST; step(4); ctrl = '0; step(2);
    chk(stat[0] == 1'b0, "R8 no match when disabled", {29'd0, stat}, 0);
    wr_cnt(32'd8);
    ctrl = C_ST | C_CE; step(3);
    chk(cnt == 32'd10 && stat[0], "R8 match flag", {29'd0, stat}, 1);
    ctrl = '0; step(2); clr(3'b111);

    // R9 capture edges
    wr_cnt(32'h77);
    ctrl = E_RISE; pin = 1'b1; step(3);
    chk(stat[2] && cap == 32'h77, "R9 rising capture", cap, 32'h77);
    clr(3'b100);
    pin = 1'b0; step(4);
    chk(!stat[2], "R9 falling ignored in rise mode", {29'd0, stat}, 0);
    ctrl = E_FALL; wr_cnt(32'h88);
    pin = 1'b1; step(4);
    chk(!stat[2], "R9 rising ignored in fall mode", {29'd0, stat}, 0);
    pin = 1'b0; step(3);
    chk(stat[2] && cap == 32'h88, "R9 falling capture", cap, 32'h88);
    clr(3'b100);
    ctrl = E_BOTH; wr_cnt(32'h99);
    pin = 1'b1; step(3);
    chk(cap == 32'h99, "R9 both rise", cap, 32'h99);
    clr(3'b100); wr_cnt(32'hAA);
    pin = 1'b0; step(3);
    chk(cap == 32'hAA, "R9 both fall", cap, 32'hAA);
    clr(3'b100);
    ctrl = '0; wr_cnt(32'hBB);
    pin = 1'b1; step(4);
    chk(!stat[2] && cap == 32'hAA, "R9 off", cap, 32'hAA);
    pin = 1'b0; step(4);

    // R10 capture hold
    ctrl = E_BOTH | C_HOLD; clr(3'b111);
    wr_cnt(32'h11);
    pin = 1'b1; step(3);
    chk(cap == 32'h11, "R10 first capture", cap, 32'h11);
    wr_cnt(32'h22);
    pin = 1'b0; step(3);
    chk(cap == 32'h11, "R10 held", cap, 32'h11);
    clr(3'b100);
    pin = 1'b1; step(3);
    chk(cap == 32'h22, "R10 after clear", cap, 32'h22);
    pin = 1'b0; ctrl = '0; step(4); clr(3'b111);

    // R12 PWM toggle on overflow
    load = 32'hFFFF_FFFC;
    wr_cnt(32'hFFFF_FFFC);
    ctrl = C_ST | C_AR | C_TGL | T_OVF; step(4);
    chk(pwm == 0, "R12 toggle before ovf", {31'd0, pwm}, 0);
    step(1);
    chk(pwm == 1, "R12 toggle at ovf", {31'd0, pwm}, 1);
    step(4);
    chk(pwm == 0, "R12 toggle at 2nd ovf", {31'd0, pwm}, 0);
    ctrl = '0; step(2);
    // R12 pulse on overflow
    wr_cnt(32'hFFFF_FFFC);
    ctrl = C_ST | C_AR | T_OVF; step(4);
    chk(pwm == 0, "R12 pulse before", {31'd0, pwm}, 0);
    step(1);
    chk(pwm == 1, "R12 pulse high", {31'd0, pwm}, 1);
    step(1);
    chk(pwm == 0, "R12 pulse one cycle", {31'd0, pwm}, 0);
    ctrl = '0; step(2);
    // R12 overflow or match
    match = 32'hFFFF_FFFE;
    wr_cnt(32'hFFFF_FFFC);
    ctrl = C_ST | C_AR | C_CE | C_TGL | T_OVM; step(2);
    chk(pwm == 0, "R12 ovm before match", {31'd0, pwm}, 0);
    step(1);
    chk(pwm == 1, "R12 ovm at match", {31'd0, pwm}, 1);
    step(2);
    chk(pwm == 0, "R12 ovm at ovf", {31'd0, pwm}, 0);
    ctrl = '0; step(2);
    // R12 no trigger
    wr_cnt(32'hFFFF_FFFC);
    ctrl = C_ST | C_AR | C_TGL; step(6);
    chk(pwm == 0, "R12 trigger none", {31'd0, pwm}, 0);
    ctrl = '0; step(2);

    // R13 default level and output enable
    ctrl = C_DEF; step(1);
    chk(pwm == 1, "R13 idle default", {31'd0, pwm}, 1);
    chk(pwm_oe == 1, "R13 oe on", {31'd0, pwm_oe}, 1);
    ctrl = C_DEF | C_GPO; step(1);
    chk(pwm_oe == 0, "R13 oe off", {31'd0, pwm_oe}, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule